// File: doc/BRIEF.md
# Registered Parity Generator with Shift

This block reports whether a 12-bit data word holds an odd count of ones. The result appears at once on a combinational output and on its complement. A force input drives that output low regardless of the data, which lets a system mask the check without touching the word itself.

A one-bit register follows the parity logic. On each capture edge it either keeps its value, takes the current parity result, or takes a serial input bit. The serial choice wins over the other two, so a chain of these blocks can be shifted as a scan string. The register captures on a rising edge of either of two clock inputs. Its reset is asynchronous, and it drives both a true and a complement output.

Top module: `parity_shift_reg`

## Requirements
- R1: With `force_low` at 0, `par_out` is 1 exactly when an odd number of the 12 bits of `data_in` are 1, and 0 otherwise.
- R2: With `force_low` at 1, `par_out` is 0 for every value of `data_in`.
- R3: `par_out_n` is always the inverse of `par_out`, and `reg_out_n` is always the inverse of `reg_out`.
- R4: At a capture edge with `shift_en` = 0 and `take_new` = 0, `reg_out` keeps its value.
- R5: At a capture edge with `shift_en` = 0 and `take_new` = 1, `reg_out` takes the value `par_out` had just before the edge, including a forced 0.
- R6: At a capture edge with `shift_en` = 1, `reg_out` takes `ser_in`, whatever `take_new` is.
- R7: A capture edge is a rising edge of `clk_a` or of `clk_b`. The internal capture clock is the OR of the two inputs, so pulses that overlap merge into one edge.
- R8: While `rst` is 1, `reg_out` is 0. It goes to 0 as soon as `rst` rises, with no clock needed, and stays 0 through capture edges that would otherwise load a 1.
- R9: After `rst` falls, the first capture edge loads the selected source, and `reg_out` then holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 12 | Data word whose parity is computed |
| force_low | input | 1 | 1 forces `par_out` to 0 |
| take_new | input | 1 | 1 loads the parity result, 0 keeps the register value (when not shifting) |
| shift_en | input | 1 | 1 loads `ser_in` into the register, over every other source |
| ser_in | input | 1 | Serial data bit for shift mode |
| clk_a | input | 1 | Capture clock, rising edge |
| clk_b | input | 1 | Second capture clock, rising edge |
| rst | input | 1 | Asynchronous reset of the register, active high |
| par_out | output | 1 | Odd-parity result |
| par_out_n | output | 1 | Complement of `par_out` |
| reg_out | output | 1 | Register output |
| reg_out_n | output | 1 | Complement of `reg_out` |

## Verification
The parity output is swept over all 4096 data words, once with the force input low and once with it high. The first sweep tells apart every odd-weight word from every even-weight one. The second shows that no word gets past the force. Register tests mix clean load, hold and shift steps with edges on each clock in turn, and with shift and load asserted together to show which one wins. A 16-bit serial pattern is also shifted in. A reset applied with no clock, and then held through a shift edge, tells an asynchronous clear apart from a clocked one.

// File: rtl/parity_shift_pkg.sv
`timescale 1ns/1ps
package parity_shift_pkg;

  localparam int unsigned PAR_DATA_W = 12;

  // Register source chosen by the select chain, listed by priority
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_SHIFT = 2'd2
  } reg_src_e;

  // Number of tree levels needed to reduce w leaves to one
  function automatic int unsigned tree_levels(input int unsigned w);
    int unsigned lv;
    lv = 0;
    while ((1 << lv) < w) lv++;
    return lv;
  endfunction

  // Decode the two select inputs into the chosen source
  function automatic reg_src_e pick_source(input logic shift_sel, input logic load_sel);
    if (shift_sel)     return SRC_SHIFT;
    else if (load_sel) return SRC_LOAD;
    else               return SRC_KEEP;
  endfunction

endpackage

// File: rtl/par_xor_tree.sv
`timescale 1ns/1ps
module par_xor_tree #(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-1:0] word,
  output logic             odd
);
  import parity_shift_pkg::*;

  localparam int unsigned LEVELS = tree_levels(WIDTH);
  localparam int unsigned LEAVES = 1 << LEVELS;

  // Zero padding up to a power of two: it leaves the parity unchanged
  logic [LEAVES-1:0] leaf;

  generate
    if (LEAVES == WIDTH) begin : g_exact
      assign leaf = word;
    end else begin : g_pad
      assign leaf = {{(LEAVES-WIDTH){1'b0}}, word};
    end
  endgenerate

  // Pairwise folding, level by level; each slot is rewritten only after its
  // two children have been read in the same pass
  always_comb begin
    logic [LEAVES-1:0] acc;
    acc = leaf;
    for (int unsigned span = LEAVES / 2; span >= 1; span = span / 2) begin
      for (int unsigned k = 0; k < span; k++) begin
        acc[k] = acc[2*k] ^ acc[2*k+1];
      end
    end
    odd = acc[0];
  end

endmodule

// File: rtl/par_load_mux.sv
`timescale 1ns/1ps
module par_load_mux (
  input  logic cur_bit,
  input  logic new_bit,
  input  logic ser_bit,
  input  logic load_sel,
  input  logic shift_sel,
  output logic stage1,
  output logic next_bit
);
  import parity_shift_pkg::*;

  // First stage: keep or load; second stage: shift overrides
  assign stage1   = load_sel ? new_bit : cur_bit;
  assign next_bit = shift_sel ? ser_bit : stage1;

endmodule

// File: rtl/par_bit_reg.sv
`timescale 1ns/1ps
module par_bit_reg #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/parity_shift_reg.sv
`timescale 1ns/1ps
module parity_shift_reg #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic              force_low,
  input  logic              take_new,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst,
  output logic              par_out,
  output logic              par_out_n,
  output logic              reg_out,
  output logic              reg_out_n
);
  import parity_shift_pkg::*;

  // Named internal events, brought out for the checker
  logic     tree_odd;
  logic     hold_pick;
  logic     reg_d;
  logic     clk_any;
  reg_src_e src_now;

  par_xor_tree #(.WIDTH(DATA_W)) u_tree (
    .word (data_in),
    .odd  (tree_odd)
  );

  assign par_out   = tree_odd & ~force_low;
  assign par_out_n = ~par_out;

  par_load_mux u_mux (
    .cur_bit   (reg_out),
    .new_bit   (par_out),
    .ser_bit   (ser_in),
    .load_sel  (take_new),
    .shift_sel (shift_en),
    .stage1    (hold_pick),
    .next_bit  (reg_d)
  );

  assign src_now = pick_source(shift_en, take_new);

  // Either clock rising captures; overlapping pulses merge
  assign clk_any = clk_a | clk_b;

  par_bit_reg #(.RESET_VAL(1'b0)) u_reg (
    .clk (clk_any),
    .rst (rst),
    .d   (reg_d),
    .q   (reg_out)
  );

  assign reg_out_n = ~reg_out;

endmodule

// File: rtl/parity_shift_reg_chk.sv
`timescale 1ns/1ps
module parity_shift_reg_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic [DATA_W-1:0] data_in,
  input logic              force_low,
  input logic              take_new,
  input logic              shift_en,
  input logic              ser_in,
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst,
  input logic              par_out,
  input logic              par_out_n,
  input logic              reg_out,
  input logic              reg_out_n
);

  logic cap_clk;
  logic since_rst;

  assign cap_clk = clk_a | clk_b;

  // 1 when a reset has happened since the previous capture edge
  always_ff @(posedge cap_clk or posedge rst) begin
    if (rst) since_rst <= 1'b1;
    else     since_rst <= 1'b0;
  end

  always_comb begin
    if (!force_low) begin
      a_r1_odd_parity: assert (par_out == (^data_in))
        else $error("R1 parity mismatch");
    end
    if (force_low) begin
      a_r2_forced_low: assert (!par_out)
        else $error("R2 force ignored");
    end
    a_r3_par_compl: assert (par_out_n == !par_out)
      else $error("R3 parity complement");
    a_r3_reg_compl: assert (reg_out_n == !reg_out)
      else $error("R3 register complement");
  end

  a_r4_hold: assert property (@(posedge cap_clk) disable iff (rst)
    (!shift_en && !take_new) |=> (since_rst || $stable(reg_out)));

  a_r5_load: assert property (@(posedge cap_clk) disable iff (rst)
    (!shift_en && take_new) |=> (since_rst || reg_out == $past(par_out)));

  a_r6_shift: assert property (@(posedge cap_clk) disable iff (rst)
    shift_en |=> (since_rst || reg_out == $past(ser_in)));

  a_r8_reset_held: assert property (@(posedge cap_clk)
    (rst && $past(rst)) |-> !reg_out);

endmodule

bind parity_shift_reg parity_shift_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .data_in   (data_in),
  .force_low (force_low),
  .take_new  (take_new),
  .shift_en  (shift_en),
  .ser_in    (ser_in),
  .clk_a     (clk_a),
  .clk_b     (clk_b),
  .rst       (rst),
  .par_out   (par_out),
  .par_out_n (par_out_n),
  .reg_out   (reg_out),
  .reg_out_n (reg_out_n)
);

// File: tb/parity_shift_reg_bench.sv
`timescale 1ns/1ps
module parity_shift_reg_bench;

  localparam int unsigned W = 12;
  localparam time HALF = 2ns;       // 250 MHz capture pulses
  localparam time WATCHDOG = 800us; // 200,000 periods

  logic [W-1:0] data_in = '0;
  logic force_low = 1'b0;
  logic take_new  = 1'b0;
  logic shift_en  = 1'b0;
  logic ser_in    = 1'b0;
  logic clk_a     = 1'b0;
  logic clk_b     = 1'b0;
  logic rst       = 1'b0;
  logic par_out, par_out_n, reg_out, reg_out_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic model;

  parity_shift_reg #(.DATA_W(W)) u_parity_shift_reg (
    .data_in   (data_in),
    .force_low (force_low),
    .take_new  (take_new),
    .shift_en  (shift_en),
    .ser_in    (ser_in),
    .clk_a     (clk_a),
    .clk_b     (clk_b),
    .rst       (rst),
    .par_out   (par_out),
    .par_out_n (par_out_n),
    .reg_out   (reg_out),
    .reg_out_n (reg_out_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Count the ones and take the remainder: independent of any XOR
  function automatic logic ones_odd(input logic [W-1:0] w);
    int c;
    c = 0;
    for (int i = 0; i < W; i++) c += int'(w[i]);
    return logic'(c % 2);
  endfunction

  // One capture pulse on the chosen clock; checks run 1 ns after the edge
  task automatic edge_on(input bit use_b);
    #HALF;
    if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
    #1ns;
  endtask

  task automatic edge_off(input bit use_b);
    #1ns;
    if (use_b) clk_b = 1'b0; else clk_a = 1'b0;
  endtask

  task automatic reg_check(input string req);
    check(req, reg_out, model);
    check("R3 reg complement", reg_out_n, ~model);
  endtask

  initial begin
    #WATCHDOG;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1ns rst = 1'b1;
    #2ns;
    model = 1'b0;
    reg_check("R8 reset state");
    rst = 1'b0;
    #1ns;

    // R1 / R2 / R3: every data word, force off and on
    for (int f = 0; f < 2; f++) begin
      force_low = logic'(f);
      for (int v = 0; v < (1 << W); v++) begin
        data_in = W'(v);
        #1ns;
        if (f == 0) check("R1 parity", par_out, ones_odd(W'(v)));
        else        check("R2 forced low", par_out, 1'b0);
        check("R3 parity complement", par_out_n, ~par_out);
      end
    end
    force_low = 1'b0;

    // R9 / R5 / R7: load an odd word on clk_a (first edge after reset)
    data_in = 12'h001; take_new = 1'b1; shift_en = 1'b0;
    edge_on(1'b0); model = 1'b1; reg_check("R9 first edge after reset"); edge_off(1'b0);
    #1ns reg_check("R9 stays until next edge");
    // R5 even word on clk_b
    data_in = 12'h003;
    edge_on(1'b1); model = 1'b0; reg_check("R5 load even via R7 clk_b"); edge_off(1'b1);
    data_in = 12'hFFE;
    edge_on(1'b1); model = 1'b1; reg_check("R5 load odd via R7 clk_b"); edge_off(1'b1);

    // R4 hold: change data, no load
    take_new = 1'b0; data_in = 12'h000;
    edge_on(1'b0); reg_check("R4 hold keeps 1"); edge_off(1'b0);
    data_in = 12'h7FF;
    edge_on(1'b1); reg_check("R4 hold ignores data"); edge_off(1'b1);

    // R5 forced parity loads 0
    take_new = 1'b1; force_low = 1'b1; data_in = 12'h001;
    edge_on(1'b0); model = 1'b0; reg_check("R5 load forced 0"); edge_off(1'b0);
    force_low = 1'b0;

    // R6 shift wins over load: parity 0, serial 1 / parity 1, serial 0
    shift_en = 1'b1; take_new = 1'b1; data_in = 12'h000; ser_in = 1'b1;
    edge_on(1'b0); model = 1'b1; reg_check("R6 shift over load"); edge_off(1'b0);
    data_in = 12'h100; ser_in = 1'b0;
    edge_on(1'b1); model = 1'b0; reg_check("R6 shift over load odd"); edge_off(1'b1);

    // R6 / R7 serial pattern, clocks alternating
    take_new = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ser_in = logic'((16'hB4D2 >> i) & 1);
      edge_on(bit'(i % 2)); model = ser_in; reg_check("R6 serial pattern R7");
      edge_off(bit'(i % 2));
    end

    // R8 asynchronous reset and priority over a shift edge
    ser_in = 1'b1;
    edge_on(1'b0); model = 1'b1; reg_check("R6 set before reset"); edge_off(1'b0);
    #1ns rst = 1'b1;
    #1ns model = 1'b0; reg_check("R8 async clear no clock");
    edge_on(1'b1); reg_check("R8 reset beats shift edge"); edge_off(1'b1);
    rst = 1'b0;
    edge_on(1'b0); model = 1'b1; reg_check("R9 first edge loads shift"); edge_off(1'b0);

    // R7 overlapping pulses merge into one edge
    ser_in = 1'b0;
    #HALF clk_a = 1'b1; #0.5ns clk_b = 1'b1; #1ns;
    model = 1'b0; reg_check("R7 merged edge");
    ser_in = 1'b1;
    #0.5ns clk_a = 1'b0; #1ns;
    reg_check("R7 no edge while other clock high");
    clk_b = 1'b0;

    done = 1'b1;
    #1ns;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule